// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for 4 KB pages. It walks a forward-mapped table in memory that has two levels. A request holds the virtual address and a write flag. The walker then reads at most two table entries through a word-read memory port. The first read fetches the outer entry, and the second fetches the leaf entry from the inner table that the outer entry locates. It returns either the physical address or a fault code in a single response cycle.

The outer table's byte address and the number of its entries are given as inputs. Both are captured at the moment a request is accepted. An outer index that falls outside the bound faults at once, with no memory traffic. Each level checks the entry's valid bit, and the leaf also checks the write permission. The walker serves one request at a time: it drops its ready signal from acceptance until the response cycle has passed.

Entry format: the frame number is in bits 31:12, valid is bit 0, and writable is bit 1. The other bits are ignored. An entry's byte address is its table base plus the index times 4.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and both `rsp_valid_o` and `mem_rd_valid_o` are 0.
- R2: The first read address is `ptbase_i + vaddr[31:22]*4`. The second read address is `{outer_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R3: If `vaddr[31:22] >= ptlen_i`, the response has `rsp_code_o` = 1 and `rsp_fault_o` = 1, and no memory read is issued.
- R4: An outer entry with bit 0 clear gives `rsp_code_o` = 2 after exactly one memory read.
- R5: A leaf entry with bit 0 clear gives `rsp_code_o` = 3. This code takes precedence over the write-permission check on the same entry.
- R6: A write (`req_write_i` = 1) to a valid leaf with bit 1 clear gives `rsp_code_o` = 4. A read of such a leaf does not fault.
- R7: A successful walk gives `rsp_fault_o` = 0, `rsp_code_o` = 0 and `rsp_paddr_o = {leaf[31:12], vaddr[11:0]}`.
- R8: A request is accepted only when `req_ready_o` is 1. `req_ready_o` stays 0 from acceptance through the response cycle. `rsp_valid_o` lasts exactly one cycle and is followed by `req_ready_o` = 1.
- R9: `mem_rd_valid_o` stays high, with a stable `mem_rd_addr_o`, until `mem_rd_ready_i` is seen. Read data is taken only on a cycle after that handshake, when `mem_rdata_valid_i` is 1.
- R10: `ptbase_i`, `ptlen_i`, `req_vaddr_i` and `req_write_i` are sampled only at acceptance. Changes while a walk is running have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| ptbase_i | input | 32 | Byte address of the outer table |
| ptlen_i | input | 11 | Number of valid outer entries (0 to 1024) |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_code_o | output | 3 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid, 4 write protect |
| rsp_paddr_o | output | 32 | Physical address on success, else 0 |
| mem_rd_valid_o | output | 1 | Memory read request |
| mem_rd_ready_i | input | 1 | Memory accepts the read |
| mem_rd_addr_o | output | 32 | Byte address of the entry to read |
| mem_rdata_valid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Returned entry |

## Verification
The inner-valid check and the write-permission check are made on the same leaf entry in the same evaluation cycle. The stimulus produces leaves that are both invalid and read-only and pairs them with write requests, in directed cases and in random ones. The test passes only if the inner-invalid code wins. Memory grant and return latency are randomized, and the base and length inputs are changed during each walk. This shows that the two dependent reads use only the values captured at acceptance.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OUTER = 3'd1,
    ST_INNER = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEN   = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_WPROT = 3'd4
  } fault_e;

  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_WR_BIT    = 1;
endpackage

// File: rtl/pt_walk_idx.sv
module pt_walk_idx #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned ENT_B  = 4
) (
  input  logic [ADDR_W-OFS_W-1:0] vpn_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-OFS_W-1:0] tbl_frame_i,
  input  logic                    inner_i,
  output logic [IDX_W-1:0]        outer_idx_o,
  output logic [ADDR_W-1:0]       entry_addr_o
);
  localparam int unsigned VPN_W  = ADDR_W - OFS_W;
  localparam int unsigned ENT_SH = $clog2(ENT_B);

  logic [IDX_W-1:0]  inner_idx, sel_idx;
  logic [ADDR_W-1:0] tbl_base, idx_off;

  assign outer_idx_o = vpn_i[VPN_W-1 -: IDX_W];
  assign inner_idx   = vpn_i[IDX_W-1:0];
  assign sel_idx     = inner_i ? inner_idx : outer_idx_o;
  assign idx_off     = ADDR_W'(sel_idx) << ENT_SH;
  assign tbl_base    = inner_i ? {tbl_frame_i, {OFS_W{1'b0}}} : base_i;
  assign entry_addr_o = tbl_base + idx_off;
endmodule

// File: rtl/pt_walk_eval.sv
module pt_walk_eval
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12
) (
  input  logic [ADDR_W-1:0]       entry_i,
  input  logic                    leaf_i,
  input  logic                    write_i,
  output fault_e                  code_o,
  output logic [ADDR_W-OFS_W-1:0] frame_o
);
  logic [OFS_W-3:0] unused_bits;
  assign unused_bits = entry_i[OFS_W-1:2];

  assign frame_o = entry_i[ADDR_W-1:OFS_W];

  // valid checked first: an invalid leaf never reports write protection
  always_comb begin
    code_o = FLT_NONE;
    if (!entry_i[ENT_VALID_BIT])
      code_o = leaf_i ? FLT_INNER : FLT_OUTER;
    else if (leaf_i && write_i && !entry_i[ENT_WR_BIT])
      code_o = FLT_WPROT;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] ptbase_i,
  input  logic [IDX_W:0]    ptlen_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [2:0]        rsp_code_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rdata_valid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  localparam int unsigned FRM_W = ADDR_W - OFS_W;
  localparam int unsigned ENT_B = ADDR_W / 8;

  walk_state_e       state_q;
  logic              issued_q, wr_q;
  logic [ADDR_W-1:0] va_q, base_q;
  logic [FRM_W-1:0]  frame_q;
  fault_e            code_q;

  logic [IDX_W-1:0]  req_outer_idx, walk_outer_idx;
  logic [ADDR_W-1:0] req_entry_addr;
  logic [ADDR_W-1:0] entry_addr;
  logic              in_walk, accept, len_bad, rd_done;
  fault_e            ent_code;
  logic [FRM_W-1:0]  ent_frame;

  // index of the incoming request, used only for the length bound
  pt_walk_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .ENT_B(ENT_B)) u_req_idx (
    .vpn_i       (req_vaddr_i[ADDR_W-1:OFS_W]),
    .base_i      (ptbase_i),
    .tbl_frame_i ('0),
    .inner_i     (1'b0),
    .outer_idx_o (req_outer_idx),
    .entry_addr_o(req_entry_addr)
  );

  pt_walk_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .ENT_B(ENT_B)) u_walk_idx (
    .vpn_i       (va_q[ADDR_W-1:OFS_W]),
    .base_i      (base_q),
    .tbl_frame_i (frame_q),
    .inner_i     (state_q == ST_INNER),
    .outer_idx_o (walk_outer_idx),
    .entry_addr_o(entry_addr)
  );

  pt_walk_eval #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_eval (
    .entry_i (mem_rdata_i),
    .leaf_i  (state_q == ST_INNER),
    .write_i (wr_q),
    .code_o  (ent_code),
    .frame_o (ent_frame)
  );

  logic [ADDR_W+IDX_W-1:0] unused_idx;
  assign unused_idx = {req_entry_addr, walk_outer_idx};

  assign in_walk = (state_q == ST_OUTER) || (state_q == ST_INNER);
  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign len_bad = {1'b0, req_outer_idx} >= ptlen_i;
  assign rd_done = in_walk && issued_q && mem_rdata_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      wr_q     <= 1'b0;
      va_q     <= '0;
      base_q   <= '0;
      frame_q  <= '0;
      code_q   <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            va_q     <= req_vaddr_i;
            wr_q     <= req_write_i;
            base_q   <= ptbase_i;
            issued_q <= 1'b0;
            if (len_bad) begin
              code_q  <= FLT_LEN;
              state_q <= ST_FAULT;
            end else begin
              code_q  <= FLT_NONE;
              state_q <= ST_OUTER;
            end
          end
        end
        ST_OUTER, ST_INNER: begin
          if (mem_rd_valid_o && mem_rd_ready_i) issued_q <= 1'b1;
          if (rd_done) begin
            issued_q <= 1'b0;
            if (ent_code != FLT_NONE) begin
              code_q  <= ent_code;
              state_q <= ST_FAULT;
            end else begin
              frame_q <= ent_frame;
              state_q <= (state_q == ST_OUTER) ? ST_INNER : ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign mem_rd_valid_o = in_walk && !issued_q;
  assign mem_rd_addr_o  = entry_addr;
  assign rsp_valid_o    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o    = (state_q == ST_FAULT);
  assign rsp_code_o     = code_q;
  assign rsp_paddr_o    = (state_q == ST_DONE) ? {frame_q, va_q[OFS_W-1:0]} : '0;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFS_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] ptbase_i,
  input logic [IDX_W:0]    ptlen_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [2:0]        rsp_code_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic              mem_rd_valid_o,
  input logic              mem_rd_ready_i,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rdata_valid_i,
  input logic [ADDR_W-1:0] mem_rdata_i
);
  logic [OFS_W-1:0] ofs_q;
  logic [1:0]       rd_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      rd_n_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      ofs_q  <= req_vaddr_i[OFS_W-1:0];
      rd_n_q <= '0;
    end else if (mem_rd_valid_o && mem_rd_ready_i && rd_n_q != 2'd3) begin
      rd_n_q <= rd_n_q + 2'd1;
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o);
  // R9
  mem_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> $stable(mem_rd_addr_o));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  // R8
  no_read_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !req_ready_o);
  // R7
  offset_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFS_W-1:0] == ofs_q && rsp_code_o == 3'd0);
  // R3
  len_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o == 3'd1 |-> rd_n_q == 2'd0 && rsp_fault_o);
  // R4
  outer_one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o == 3'd2 |-> rd_n_q == 2'd1);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic [31:0] ptbase_i = '0;
  logic [10:0] ptlen_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [2:0]  rsp_code_o;
  logic [31:0] rsp_paddr_o;
  logic        mem_rd_valid_o;
  logic        mem_rd_ready_i = 1'b0;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rdata_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  pt_walker dut (.*);

  logic [31:0] mem [4096];
  int checks = 0, errors = 0;
  int rd_n = 0;
  logic [31:0] rd_a [2];
  bit hs_next = 0, pend = 0;
  logic [31:0] hs_addr, pend_addr;
  int lat = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: grant and return latency randomized
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      mem_rdata_valid_i = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rdata_valid_i = 1'b1;
          mem_rdata_i = mem[pend_addr[13:2]];
          pend = 0;
        end else lat--;
      end
      if (hs_next) begin
        pend = 1;
        pend_addr = hs_addr;
        lat = $urandom_range(0, 3);
        if (rd_n < 2) rd_a[rd_n] = hs_addr;
        rd_n++;
      end
      mem_rd_ready_i = ($urandom_range(0, 3) != 0);
      hs_next = mem_rd_valid_o && mem_rd_ready_i;
      hs_addr = mem_rd_addr_o;
    end
  end

  task automatic model(input logic [31:0] va, input bit wr, input logic [31:0] base,
                       input logic [10:0] len, output logic [2:0] code,
                       output logic [31:0] pa, output int nrd,
                       output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] e0, e1;
    a0 = base + {20'd0, va[31:22], 2'b00};
    a1 = '0; pa = '0; nrd = 0; code = 3'd0;
    if ({1'b0, va[31:22]} >= len) begin code = 3'd1; return; end
    e0 = mem[a0[13:2]]; nrd = 1;
    if (!e0[0]) begin code = 3'd2; return; end
    a1 = {e0[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    e1 = mem[a1[13:2]]; nrd = 2;
    if (!e1[0]) code = 3'd3;
    else if (wr && !e1[1]) code = 3'd4;
    else pa = {e1[31:12], va[11:0]};
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                      input logic [10:0] len, input string req);
    logic [2:0] ecode; logic [31:0] epa, ea0, ea1; int enrd;
    int guard = 0; bit busy_bad = 0;
    model(va, wr, base, len, ecode, epa, enrd, ea0, ea1);
    @(negedge clk_i);
    while (!req_ready_o && guard < 100) begin @(negedge clk_i); guard++; end
    rd_n = 0;
    req_valid_i = 1'b1; req_vaddr_i = va; req_write_i = wr;
    ptbase_i = base; ptlen_i = len;
    @(negedge clk_i);
    // R10: scramble the captured inputs while the walk runs
    req_valid_i = 1'b0; req_vaddr_i = $urandom; req_write_i = ~wr;
    ptbase_i = $urandom; ptlen_i = 11'($urandom);
    guard = 0;
    while (!rsp_valid_o && guard < 200) begin
      if (req_ready_o) busy_bad = 1;
      @(negedge clk_i); guard++;
    end
    chk(guard < 200, "R8", "response timeout", 32'(guard), 32'd200);
    chk(!busy_bad, "R8", "ready while busy", 32'(busy_bad), 32'd0);
    chk(rsp_code_o == ecode, req, "R10 fault code", 32'(rsp_code_o), 32'(ecode));
    chk(rsp_fault_o == (ecode != 3'd0), req, "fault flag", 32'(rsp_fault_o), 32'(ecode != 0));
    chk(rsp_paddr_o == epa, "R7", "physical address", rsp_paddr_o, epa);
    chk(rd_n == enrd, "R3", "memory read count", 32'(rd_n), 32'(enrd));
    if (enrd >= 1) chk(rd_a[0] == ea0, "R2", "outer entry address", rd_a[0], ea0);
    if (enrd >= 2) chk(rd_a[1] == ea1, "R2", "inner entry address", rd_a[1], ea1);
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R8", "pulse then ready",
        {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin
      logic [1:0] fl;
      fl = 2'($urandom);
      if ($urandom_range(0, 7) != 0) fl[0] = 1'b1;
      if (i < 1024) mem[i] = {20'($urandom_range(1, 3)), 10'($urandom), fl};
      else          mem[i] = {20'($urandom), 10'($urandom), fl};
    end
    mem[5]       = {20'd1, 10'd0, 2'b01};
    mem[6]       = {20'd2, 10'h3ff, 2'b10};
    mem[1024+7]  = {20'hABCDE, 10'd0, 2'b01};
    mem[1024+8]  = {20'h12345, 10'd0, 2'b11};
    mem[1024+9]  = {20'h0F0F0, 10'h3ff, 2'b00};
    mem[1023]    = {20'd3, 10'd0, 2'b11};

    repeat (3) @(negedge clk_i);
    // R1
    chk(req_ready_o && !rsp_valid_o && !mem_rd_valid_o, "R1", "reset outputs",
        {29'd0, req_ready_o, rsp_valid_o, mem_rd_valid_o}, 32'h4);
    rst_ni = 1'b1;

    walk({10'd5, 10'd7, 12'h123}, 1'b0, 32'h0, 11'd1024, "R7");  // read of read-only leaf
    walk({10'd5, 10'd7, 12'h123}, 1'b1, 32'h0, 11'd1024, "R6");  // write protect
    walk({10'd5, 10'd8, 12'hFFF}, 1'b1, 32'h0, 11'd1024, "R7");  // writable leaf
    walk({10'd5, 10'd9, 12'h000}, 1'b1, 32'h0, 11'd1024, "R5");  // invalid and read-only
    walk({10'd6, 10'd1, 12'h010}, 1'b0, 32'h0, 11'd1024, "R4");
    walk({10'd5, 10'd7, 12'h001}, 1'b0, 32'h0, 11'd5,    "R3");  // index equals bound
    walk({10'd5, 10'd7, 12'h002}, 1'b0, 32'h0, 11'd6,    "R7");  // index just inside
    walk({10'd0, 10'd0, 12'h000}, 1'b0, 32'h0, 11'd0,    "R3");
    walk({10'd1023, 10'd1023, 12'hABC}, 1'b0, 32'h0, 11'd1024, "R2");

    for (int n = 0; n < 300; n++) begin
      logic [31:0] va, base; logic [10:0] len;
      va   = $urandom;
      base = ($urandom_range(0, 3) == 0) ? {18'd0, 2'($urandom), 12'h000} : 32'h0;
      len  = ($urandom_range(0, 3) == 0) ? 11'($urandom_range(0, 1024)) : 11'd1024;
      walk(va, 1'($urandom), base, len, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule